// File: doc/BRIEF.md
# Stream FIFO Level Interrupt Generator

This block produces two interrupt request lines for a group of stream link FIFOs: one for the receive side and one for the transmit side. Each line is shared by all links of its direction. The block watches one fill-level condition bit per link and turns a change of that bit into a trigger. Which change counts depends on the FIFO depth set at build time. When the depth is 1, the block fires when a receive FIFO gains a word or a transmit FIFO drains to empty. When the depth is larger, it fires when a receive FIFO climbs to half full or a transmit FIFO falls back below half full.

A raised request stays high until the CPU reads the status register. That read arrives as a one-cycle strobe, which acts as the acknowledge. The block remembers a trigger that arrives while a request is outstanding and raises a fresh request one cycle after the acknowledge. A global enable gates everything. While the enable is low no trigger counts, and dropping the enable wipes every raised and remembered request. Finding which link caused an interrupt is left to software, which reads the per-link status.

Top module: `slk_irq_gen`

## Requirements
- R1: While reset is active, and after it is released, both requests are low. A condition bit that is already at its trigger level on the first cycle after reset causes no trigger.
- R2: With receive depth above 1, bit i of `rx_cond_i` set means FIFO i is at least half full. A 0-to-1 change of any bit raises `irq_rx_o` on the next clock edge.
- R3: With transmit depth above 1, bit i of `tx_cond_i` set means FIFO i is more than half full. A 1-to-0 change of any bit raises `irq_tx_o`. A 0-to-1 change raises nothing.
- R4: With depth 1, bit i of `rx_cond_i` set means FIFO i holds a word, and bit i of `tx_cond_i` set means FIFO i is empty. A 0-to-1 change of any bit raises the request for that direction, and a 1-to-0 change raises nothing.
- R5: A raised request stays high until it is acknowledged. A condition that holds steady at its trigger level causes no further trigger.
- R6: A cycle with `stat_rd_i` high drops a raised request on the next edge. When no request is raised, `stat_rd_i` has no effect, and a trigger in that same cycle still raises a request.
- R7: A trigger that arrives while a request is raised is remembered. This includes a trigger in the acknowledge cycle. After the acknowledge, the request is low for one cycle and then high again.
- R8: While `en_i` is low, no request is raised and no trigger is remembered. Driving `en_i` low clears both the raised and the remembered state. Changes of condition bits that happen while disabled do not fire after `en_i` returns high.
- R9: The receive and transmit paths are independent. Triggers, acknowledges and remembered state on one side never change the other side, apart from the shared acknowledge strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable |
| stat_rd_i | input | 1 | Strobe marking a CPU read of the status register (acknowledge) |
| rx_cond_i | input | NUM_RX | Per-link receive fill condition (meaning set by RX_DEPTH) |
| tx_cond_i | input | NUM_TX | Per-link transmit fill condition (meaning set by TX_DEPTH) |
| irq_rx_o | output | 1 | Receive interrupt request |
| irq_tx_o | output | 1 | Transmit interrupt request |

## Verification
The bench targets triggers that land in the acknowledge cycle. A design that gives the acknowledge priority and drops such a trigger would leave the request low for good. It also checks that a strobe on an idle line does not swallow a simultaneous trigger, and that dropping the enable discards a remembered trigger, so a design that kept it would fire again on re-enable. Edges that happen while disabled must stay invisible afterwards, which catches a detector that stops tracking while disabled. A second instance built with depth 1 confirms the polarity switch on the transmit side. A design with the wrong polarity would fire when the FIFO fills instead of when it drains.

// File: rtl/slk_irq_pkg.sv
package slk_irq_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;

  // Receive side always fires on a rising condition (word arrives / half reached).
  function automatic edge_pol_e rx_pol(input int unsigned depth);
    rx_pol = (depth >= 1) ? EDGE_RISE : EDGE_RISE;
  endfunction

  // Transmit side: depth 1 fires on "became empty" (rise), deeper on dropping below half (fall).
  function automatic edge_pol_e tx_pol(input int unsigned depth);
    tx_pol = (depth == 1) ? EDGE_RISE : EDGE_FALL;
  endfunction

endpackage

// File: rtl/slk_edge_det.sv
module slk_edge_det
  import slk_irq_pkg::*;
#(
  parameter int unsigned N   = 4,
  parameter edge_pol_e   POL = EDGE_RISE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond_i,
  output logic         hit_o
);

  // Reset value is the level that makes the watched edge impossible on the first cycle.
  localparam logic [N-1:0] PREV_RST = (POL == EDGE_RISE) ? {N{1'b1}} : {N{1'b0}};

  logic [N-1:0] prev_q;
  logic [N-1:0] edges;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= PREV_RST;
    else        prev_q <= cond_i;
  end

  generate
    if (POL == EDGE_RISE) begin : g_rise
      assign edges = cond_i & ~prev_q;
    end else begin : g_fall
      assign edges = ~cond_i & prev_q;
    end
  endgenerate

  assign hit_o = |edges;

endmodule

// File: rtl/slk_irq_chan.sv
module slk_irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic ack_i,
  input  logic trig_i,
  output logic req_o
);

  logic active_q, pend_q;
  logic ack_evt, raise_evt;

  assign ack_evt   = en_i & active_q & ack_i;
  assign raise_evt = en_i & ~active_q & (pend_q | trig_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
    end else if (active_q) begin
      if (ack_i) active_q <= 1'b0;
      pend_q <= pend_q | trig_i;
    end else if (raise_evt) begin
      active_q <= 1'b1;
      pend_q   <= 1'b0;
    end
  end

  assign req_o = active_q;

  p_ack_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> !req_o);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && active_q && !ack_i) |=> req_o);

  p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && (pend_q || trig_i)) ##1 en_i |=> req_o);

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!req_o && !pend_q));

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !pend_q && !trig_i) |=> !req_o);

endmodule

// File: rtl/slk_irq_gen.sv
module slk_irq_gen
  import slk_irq_pkg::*;
#(
  parameter int unsigned NUM_RX   = 4,
  parameter int unsigned NUM_TX   = 4,
  parameter int unsigned RX_DEPTH = 8,
  parameter int unsigned TX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              stat_rd_i,
  input  logic [NUM_RX-1:0] rx_cond_i,
  input  logic [NUM_TX-1:0] tx_cond_i,
  output logic              irq_rx_o,
  output logic              irq_tx_o
);

  localparam edge_pol_e RX_POL = rx_pol(RX_DEPTH);
  localparam edge_pol_e TX_POL = tx_pol(TX_DEPTH);

  logic rx_trig, tx_trig;

  slk_edge_det #(.N(NUM_RX), .POL(RX_POL)) u_rx_edge (
    .clk(clk), .rst_n(rst_n), .cond_i(rx_cond_i), .hit_o(rx_trig));

  slk_edge_det #(.N(NUM_TX), .POL(TX_POL)) u_tx_edge (
    .clk(clk), .rst_n(rst_n), .cond_i(tx_cond_i), .hit_o(tx_trig));

  slk_irq_chan u_rx_chan (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .ack_i(stat_rd_i),
    .trig_i(rx_trig), .req_o(irq_rx_o));

  slk_irq_chan u_tx_chan (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .ack_i(stat_rd_i),
    .trig_i(tx_trig), .req_o(irq_tx_o));

  p_idle_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_tx_o && !tx_trig && !u_tx_chan.pend_q) |=> !irq_tx_o);

endmodule

// File: tb/slk_irq_gen_tb.sv
module slk_irq_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int NVEC = 32;

  // {en, rd, rx[3:0], tx[3:0], exp_rx, exp_tx}
  typedef logic [11:0] vec_t;
  localparam vec_t VECS [NVEC] = '{
    12'b1_0_0000_0000_0_0, // 0  R1 no trigger from reset
    12'b1_0_0001_0000_1_0, // 1  R2 rise
    12'b1_0_0001_0000_1_0, // 2  R5 held
    12'b1_0_0011_0000_1_0, // 3  R7 buffered
    12'b1_1_0011_0000_0_0, // 4  R6 ack
    12'b1_0_0011_0000_1_0, // 5  R7 rearm
    12'b1_1_0011_0000_0_0, // 6  R6
    12'b1_0_0011_0000_0_0, // 7  R5 stays low
    12'b1_0_0011_1100_0_0, // 8  R3 rise ignored
    12'b1_0_0011_0100_0_1, // 9  R3 fall
    12'b1_0_0111_0000_1_1, // 10 R9 both
    12'b1_1_0111_0000_0_0, // 11 R6 both ack
    12'b1_0_0111_0000_0_1, // 12 R7 tx rearm only, R9
    12'b1_1_0111_1000_0_0, // 13 R6
    12'b0_0_1111_0000_0_0, // 14 R8 disabled edges
    12'b1_0_1111_0000_0_0, // 15 R8 not remembered
    12'b1_0_0000_0000_0_0, // 16
    12'b1_0_0001_0000_1_0, // 17 R2
    12'b1_0_0001_0010_1_0, // 18 R3
    12'b1_0_0001_0000_1_1, // 19 R3 fall
    12'b0_0_0001_0000_0_0, // 20 R8 clears
    12'b1_0_0001_0000_0_0, // 21 R8
    12'b1_0_0011_0000_1_0, // 22 R2
    12'b1_0_0111_0000_1_0, // 23 R7 pending
    12'b0_0_0111_0000_0_0, // 24 R8 pending wiped
    12'b1_0_0111_0000_0_0, // 25 R8
    12'b1_1_1111_0000_1_0, // 26 R6 strobe while idle
    12'b1_1_1111_0000_0_0, // 27 R6
    12'b1_0_0000_0000_0_0, // 28
    12'b1_0_0001_0000_1_0, // 29
    12'b1_1_0011_0000_0_0, // 30 R7 trigger in ack cycle
    12'b1_0_0011_0000_1_0  // 31 R7 rearm
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, rd = 1'b0;
  logic [N-1:0] rx = '0, tx = '0;
  logic irq_rx, irq_tx;
  logic en1 = 1'b0, rd1 = 1'b0;
  logic [N-1:0] rx1 = '0, tx1 = '1;
  logic irq_rx1, irq_tx1;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slk_irq_gen #(.NUM_RX(N), .NUM_TX(N), .RX_DEPTH(8), .TX_DEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .stat_rd_i(rd),
    .rx_cond_i(rx), .tx_cond_i(tx), .irq_rx_o(irq_rx), .irq_tx_o(irq_tx));

  slk_irq_gen #(.NUM_RX(N), .NUM_TX(N), .RX_DEPTH(1), .TX_DEPTH(1)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .en_i(en1), .stat_rd_i(rd1),
    .rx_cond_i(rx1), .tx_cond_i(tx1), .irq_rx_o(irq_rx1), .irq_tx_o(irq_tx1));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step1(input logic e, input logic r, input logic [N-1:0] rv, input logic [N-1:0] tv);
    en1 = e; rd1 = r; rx1 = rv; tx1 = tv;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    en = 1'b1; en1 = 1'b1;
    rx1 = 4'b1111; // depth-1 rx already holding at reset: no trigger (R1)
    repeat (3) @(negedge clk);
    chk("R1 reset rx", irq_rx, 1'b0);
    chk("R1 reset tx", irq_tx, 1'b0);
    chk("R1 reset rx depth1", irq_rx1, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rx after release", irq_rx1, 1'b0);
    chk("R1 tx after release", irq_tx1, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      en = VECS[i][11]; rd = VECS[i][10];
      rx = VECS[i][9:6]; tx = VECS[i][5:2];
      @(negedge clk);
      chk($sformatf("R2/R3/R5-R9 vec%0d rx", i), irq_rx, VECS[i][1]);
      chk($sformatf("R2/R3/R5-R9 vec%0d tx", i), irq_tx, VECS[i][0]);
    end

    // depth-1 directed tests (R4)
    step1(1'b1, 1'b0, 4'b0000, 4'b1111);
    chk("R4 rx fall no fire", irq_rx1, 1'b0);
    step1(1'b1, 1'b0, 4'b0000, 4'b1110);
    chk("R4 tx fill no fire", irq_tx1, 1'b0);
    step1(1'b1, 1'b0, 4'b0000, 4'b1111);
    chk("R4 tx empty fires", irq_tx1, 1'b1);
    chk("R9 rx unaffected", irq_rx1, 1'b0);
    step1(1'b1, 1'b0, 4'b0100, 4'b1111);
    chk("R4 rx word fires", irq_rx1, 1'b1);
    step1(1'b1, 1'b1, 4'b0100, 4'b1111);
    chk("R6 depth1 ack rx", irq_rx1, 1'b0);
    chk("R6 depth1 ack tx", irq_tx1, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule